// File: doc/BRIEF.md
# Multi-Channel Pattern and Edge Trigger

This block watches sixteen logic inputs that are sampled together on a shared sample strobe. It raises a trigger once every participating channel meets its own condition on a strobe. Each channel is configured on its own. It can be left out of the decision, it can require a fixed level, or it can require a transition that ends at a chosen level.

Software programs the block through two 32-bit write ports, each made of a data word and a write enable. The condition word holds one edge-select bit and one match-value bit for each channel. The control word holds a participation mask and an arm bit. When the conditions are met, the block gives a single-cycle trigger pulse and sets a sticky triggered flag. That flag stays high until the next control write. Writing the control word with the arm bit clear disarms the unit.

Top module: `trig_match_unit`

## Requirements
- R1: While reset is asserted and after it is released, `trig_pulse` and `trig_flag` are 0 and the unit is disarmed until a control word with bit 2 set is written.
- R2: A write to the condition word loads the edge-select bits from bits [31:16] and the match values from bits [15:0], with bit n of each half belonging to channel n. The new values govern strobes from the next clock cycle on.
- R3: A control write loads the participation mask from bits [31:16] and the arm bit from bit 2. A write with bit 2 clear disarms the unit, and no pulse follows while disarmed. Any control write clears `trig_flag`.
- R4: A channel whose mask bit is 0 plays no part in the decision. With an all-zero mask and the unit armed, the first evaluated strobe fires.
- R5: A participating channel with edge-select 0 matches when its strobed sample equals its match value.
- R6: A participating channel with edge-select 1 matches when its strobed sample equals its match value and differs from that channel's sample at the previous evaluated strobe. Value 1 gives a rising edge and value 0 a falling edge.
- R7: The previous sample is the one taken at the previous evaluated strobe, not the previous clock cycle. The first evaluated strobe after any control write never gives an edge match.
- R8: `trig_pulse` is high for exactly one clock cycle. That cycle follows the clock edge where an evaluated strobe found all participating channels matching.
- R9: `trig_flag` rises together with the pulse and stays high until the next control write. At most one pulse occurs per control write.
- R10: A strobe in the same cycle as a control write is discarded. It cannot fire, and it is not kept as a previous sample.
- R11: A strobe in the same cycle as a condition write is judged with the condition values in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Condition word write enable |
| sel_wdata | input | 32 | Condition word: edge selects [31:16], match values [15:0] |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 32 | Control word: mask [31:16], arm bit 2 |
| smp_stb | input | 1 | Sample strobe, qualifies `smp_data` |
| smp_data | input | 16 | Channel samples |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_flag | output | 1 | Sticky triggered flag |

## Verification
Two kinds of event can fall in the same cycle, and both are provoked on purpose. The first is a sample strobe together with a control write. The second is a sample strobe together with a condition write. Directed cases place a strobe that would fire in the same cycle as a re-arming control write, and place a strobe that matches only the old condition values in the same cycle as a condition write. The random phase also lets both coincidences occur freely. In each case the bench's own model decides the outcome: the control write wins and discards the strobe, while the condition write takes effect only for later strobes. The bench then compares the pulse and flag at the next falling edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned TRG_CH   = 16;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ARM_BIT  = 2;
  localparam int unsigned HI_LSB   = WORD_W - TRG_CH;

  typedef struct packed {
    logic [TRG_CH-1:0] edge_sel;
    logic [TRG_CH-1:0] match_val;
  } trig_cond_t;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [WORD_W-1:0] sel_wdata,
  input  logic              ctl_we,
  input  logic [TRG_CH-1:0] ctl_mask_in,
  input  logic              ctl_arm_in,
  output trig_cond_t        cond,
  output logic [TRG_CH-1:0] chan_mask,
  output logic              armed
);
  trig_cond_t        cond_d;
  logic [TRG_CH-1:0] mask_d;
  logic              arm_d;

  always_comb begin
    cond_d = cond;
    mask_d = chan_mask;
    arm_d  = armed;
    if (sel_we) begin
      cond_d.edge_sel  = sel_wdata[WORD_W-1:HI_LSB];
      cond_d.match_val = sel_wdata[TRG_CH-1:0];
    end
    if (ctl_we) begin
      mask_d = ctl_mask_in;
      arm_d  = ctl_arm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond      <= '0;
      chan_mask <= '0;
      armed     <= 1'b0;
    end else begin
      cond      <= cond_d;
      chan_mask <= mask_d;
      armed     <= arm_d;
    end
  end
endmodule

// File: rtl/trig_chan_match.sv
module trig_chan_match
  import trig_pkg::*;
#(
  parameter int unsigned NCH = TRG_CH
) (
  input  logic [NCH-1:0] edge_sel,
  input  logic [NCH-1:0] match_val,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] cur_smp,
  input  logic [NCH-1:0] prev_smp,
  input  logic           prev_ok,
  output logic           all_hit
);
  logic [NCH-1:0] ch_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic lvl_hit;
    logic edg_hit;
    assign lvl_hit = (cur_smp[g] == match_val[g]);
    assign edg_hit = lvl_hit && prev_ok && (prev_smp[g] != cur_smp[g]);
    assign ch_ok[g] = !chan_mask[g] || (edge_sel[g] ? edg_hit : lvl_hit);
  end

  assign all_hit = &ch_ok;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [TRG_CH-1:0] smp_data,
  input  logic              ctl_we,
  input  logic              armed,
  input  logic              all_hit,
  output logic [TRG_CH-1:0] prev_smp,
  output logic              prev_ok,
  output logic              trig_pulse,
  output logic              trig_flag
);
  logic              eval_en;
  logic              fire;
  logic [TRG_CH-1:0] prev_d;
  logic              prev_ok_d;
  logic              flag_d;

  always_comb begin
    eval_en   = smp_stb && !ctl_we && armed;
    fire      = eval_en && !trig_flag && all_hit;
    prev_d    = prev_smp;
    prev_ok_d = prev_ok;
    flag_d    = trig_flag | fire;
    if (eval_en) begin
      prev_d    = smp_data;
      prev_ok_d = 1'b1;
    end
    if (ctl_we) begin
      prev_ok_d = 1'b0;
      flag_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_smp   <= '0;
      prev_ok    <= 1'b0;
      trig_pulse <= 1'b0;
      trig_flag  <= 1'b0;
    end else begin
      prev_smp   <= prev_d;
      prev_ok    <= prev_ok_d;
      trig_pulse <= fire;
      trig_flag  <= flag_d;
    end
  end
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [WORD_W-1:0] sel_wdata,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              smp_stb,
  input  logic [TRG_CH-1:0] smp_data,
  output logic              trig_pulse,
  output logic              trig_flag
);
  trig_cond_t        cond;
  logic [TRG_CH-1:0] chan_mask;
  logic              armed;
  logic [TRG_CH-1:0] prev_smp;
  logic              prev_ok;
  logic              all_hit;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[HI_LSB-1:ARM_BIT+1], ctl_wdata[ARM_BIT-1:0]};

  trig_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_we      (sel_we),
    .sel_wdata   (sel_wdata),
    .ctl_we      (ctl_we),
    .ctl_mask_in (ctl_wdata[WORD_W-1:HI_LSB]),
    .ctl_arm_in  (ctl_wdata[ARM_BIT]),
    .cond        (cond),
    .chan_mask   (chan_mask),
    .armed       (armed)
  );

  trig_chan_match #(.NCH(TRG_CH)) u_match (
    .edge_sel  (cond.edge_sel),
    .match_val (cond.match_val),
    .chan_mask (chan_mask),
    .cur_smp   (smp_data),
    .prev_smp  (prev_smp),
    .prev_ok   (prev_ok),
    .all_hit   (all_hit)
  );

  trig_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .smp_data   (smp_data),
    .ctl_we     (ctl_we),
    .armed      (armed),
    .all_hit    (all_hit),
    .prev_smp   (prev_smp),
    .prev_ok    (prev_ok),
    .trig_pulse (trig_pulse),
    .trig_flag  (trig_flag)
  );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk
  import trig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [WORD_W-1:0] ctl_wdata,
  input logic              smp_stb,
  input logic              trig_pulse,
  input logic              trig_flag
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^{ctl_wdata[WORD_W-1:ARM_BIT+1], ctl_wdata[ARM_BIT-1:0]};

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  a_r8_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_pulse) |-> $past(smp_stb));

  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_flag);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !ctl_we) |=> trig_flag);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !ctl_we) |=> !trig_pulse);

  a_r3_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[ARM_BIT]) |=> (!trig_flag && !trig_pulse));

  a_r10_ctl_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (!trig_pulse && !trig_flag));
endmodule

bind trig_match_unit trig_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .smp_stb    (smp_stb),
  .trig_pulse (trig_pulse),
  .trig_flag  (trig_flag)
);

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;
  logic        clk;
  logic        rst_n;
  logic        sel_we;
  logic [31:0] sel_wdata;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic        smp_stb;
  logic [15:0] smp_data;
  logic        trig_pulse;
  logic        trig_flag;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  // reference model state
  logic [15:0] m_edge, m_val, m_mask, m_prev;
  logic        m_arm, m_pv, m_flag, e_pulse;

  trig_match_unit dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .smp_stb(smp_stb),
    .smp_data(smp_data), .trig_pulse(trig_pulse), .trig_flag(trig_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      finish_run();
    end
  end

  function automatic logic model_hit(logic [15:0] dat);
    logic ok = 1'b1;
    for (int ch = 0; ch < 16; ch++) begin
      if (m_mask[ch]) begin
        logic lvl = (dat[ch] == m_val[ch]);
        if (m_edge[ch]) ok &= lvl && m_pv && (m_prev[ch] != dat[ch]);
        else            ok &= lvl;
      end
    end
    return ok;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic swe, logic [31:0] sd, logic cwe,
                      logic [31:0] cd, logic stb, logic [15:0] dat);
    logic ev;
    sel_we = swe; sel_wdata = sd; ctl_we = cwe; ctl_wdata = cd;
    smp_stb = stb; smp_data = dat;
    @(posedge clk);
    ev      = stb && !cwe && m_arm;
    e_pulse = ev && !m_flag && model_hit(dat);
    if (cwe) begin
      m_mask = cd[31:16]; m_arm = cd[2]; m_flag = 1'b0; m_pv = 1'b0;
    end else begin
      m_flag = m_flag | e_pulse;
    end
    if (ev) begin m_prev = dat; m_pv = 1'b1; end
    if (swe) begin m_edge = sd[31:16]; m_val = sd[15:0]; end
    @(negedge clk);
    check(tag, trig_pulse, e_pulse, "pulse");
    check(tag, trig_flag, m_flag, "flag");
  endtask

  task automatic idle(string tag, logic [15:0] dat);
    step(tag, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, dat);
  endtask
  task automatic strobe(string tag, logic [15:0] dat);
    step(tag, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, dat);
  endtask
  task automatic wsel(string tag, logic [31:0] w);
    step(tag, 1'b1, w, 1'b0, 32'h0, 1'b0, 16'h0);
  endtask
  task automatic wctl(string tag, logic [31:0] w);
    step(tag, 1'b0, 32'h0, 1'b1, w, 1'b0, 16'h0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    m_edge = '0; m_val = '0; m_mask = '0; m_prev = '0;
    m_arm = 1'b0; m_pv = 1'b0; m_flag = 1'b0; e_pulse = 1'b0;
    sel_we = 0; sel_wdata = 0; ctl_we = 0; ctl_wdata = 0; smp_stb = 0; smp_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", trig_pulse, 1'b0, "pulse in reset");
    check("R1", trig_flag, 1'b0, "flag in reset");
    rst_n = 1'b1;
    // R1: strobes before any arming do nothing
    strobe("R1", 16'h0000);
    strobe("R1", 16'hFFFF);

    // R4: empty mask fires on first strobe; R8 single-cycle pulse; R9 sticky
    wctl("R4", 32'h0000_0004);
    strobe("R4", 16'h1234);
    idle("R8", 16'h0);
    strobe("R9", 16'h0);
    idle("R9", 16'h0);
    // R3: disarm clears flag, no further pulses
    wctl("R3", 32'h0000_0000);
    strobe("R3", 16'h0);
    strobe("R3", 16'hFFFF);

    // R5: level match on channel 3 = 1, other channels ignored (R4)
    wsel("R2", 32'h0000_0008);
    wctl("R5", 32'h0008_0004);
    strobe("R5", 16'hFFF7);
    strobe("R5", 16'h0008);

    // R6: rising edge on channel 0; R7 first strobe gives no edge
    wsel("R2", 32'h0001_0001);
    wctl("R7", 32'h0001_0004);
    strobe("R7", 16'h0001);
    strobe("R6", 16'h0000);
    strobe("R6", 16'h0001);
    // R6: falling edge on channel 0
    wsel("R2", 32'h0001_0000);
    wctl("R6", 32'h0001_0004);
    strobe("R6", 16'h0001);
    strobe("R6", 16'h0000);

    // R7: previous sample is from previous strobe, not previous clock
    wsel("R2", 32'h0001_0001);
    wctl("R7", 32'h0001_0004);
    strobe("R7", 16'h0001);
    idle("R7", 16'h0000);
    strobe("R7", 16'h0001);   // no edge: last strobed value was 1
    idle("R7", 16'h0001);
    strobe("R7", 16'h0000);
    idle("R7", 16'h0001);
    strobe("R7", 16'h0001);   // edge: last strobed value was 0

    // R10: strobe coinciding with control write is discarded
    step("R10", 1'b0, 32'h0, 1'b1, 32'h0000_0004, 1'b1, 16'h0);
    strobe("R10", 16'h0);
    wsel("R2", 32'h0001_0001);
    wctl("R10", 32'h0001_0004);
    strobe("R10", 16'h0000);
    step("R10", 1'b0, 32'h0, 1'b1, 32'h0001_0004, 1'b1, 16'h0001);
    strobe("R10", 16'h0001);  // first strobe after write: no edge

    // R11: condition write in same cycle as strobe uses old condition
    wsel("R2", 32'h0000_0000);
    wctl("R11", 32'h0002_0004);
    step("R11", 1'b1, 32'h0000_0002, 1'b0, 32'h0, 1'b1, 16'h0002); // old val 0 -> no
    strobe("R11", 16'h0002);  // new val 1 -> fire

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic swe, cwe, stb;
      logic [31:0] sd, cd;
      logic [15:0] dat;
      swe = ($urandom % 20) == 0;
      cwe = ($urandom % 25) == 0;
      stb = ($urandom % 2) == 0;
      sd  = $urandom;
      cd  = {16'($urandom & $urandom & $urandom), 13'($urandom), (($urandom % 6) != 0), 2'($urandom)};
      dat = smp_data ^ 16'($urandom & $urandom & $urandom);
      step("R2 R5 R6 R9 random", swe, sd, cwe, cd, stb, dat);
    end

    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
  end
endmodule